// File: doc/BRIEF.md
# Flash Status Register with Protection Lock

This block keeps the 8-bit status register of a serial flash target and decides whether status writes may happen. A command decoder outside this block sends it one-cycle strobes. The strobes cover write-enable, write-disable, the arm that precedes a status write, the status write itself (with its data byte), any other command, completion of a byte program or erase, and entry to, exit from or end of the auto-increment program run. A separate input carries the level of the active-low write-protect pin.

The block drives three outputs. The first is the register image. The second is a combinational flag that says whether a 24-bit address falls inside the region the protection level guards. The third permits a whole-array erase.

A status write takes effect only when three conditions hold. It must come straight after an arm or write-enable command. The pin must be high or the lock bit clear. Once the lock bit is set while the pin is low, only raising the pin lets it be cleared again. Every strobe is sampled on the rising clock edge and the register updates on that same edge.

Top module: `flash_status_reg`

## Requirements
- R1: After reset the register reads 8'h1C. The bits are: bit0 busy, bit1 write-enable latch, bits 5:2 protection level PL3..PL0 (PL0 at bit 2), bit6 auto-increment mode, bit7 lock. At reset PL2..PL0 are 1 and every other bit is 0.
- R2: Bit0 shows busy_i as sampled at the previous clock edge. A status write never changes bit0.
- R3: cmd_wr_en_i sets the write-enable latch. A status write is accepted only if the command strobe just before it was cmd_wr_en_i or cmd_sr_arm_i. Otherwise the register is left unchanged.
- R4: A status write with prot_pin_n_i low and the lock bit at 1 is refused, and all bits stay as they were, including the latch. With the pin high, the write is accepted even when the lock bit is 1.
- R5: An accepted status write loads bits 7 and 5:2 from the same bit positions of sr_data_i and clears the write-enable latch. Bit 6 is left unchanged. With the pin low and the lock clear, one write may set the lock bit and new level bits together.
- R6: The write-enable latch clears on write-disable, program done, erase done, auto-increment exit, and auto-increment reaching the top address. Write-disable, exit and top-reached also clear bit6.
- R7: incr_enter_i sets bit6 only while the write-enable latch is 1.
- R8: addr_prot_o is set when the address offset within a 2 MiB space is protected. The offset is address bits 20:0; bits 23:21 are ignored. PL2..PL0 values 1 to 5 guard the top 1/32, 1/16, 1/8, 1/4 and 1/2. Values 6 and 7 guard everything, and value 0 guards nothing. PL3 has no effect on this flag.
- R9: chip_erase_ok_o is 1 exactly when PL3..PL0 are all zero.
- R10: Any command strobe other than write-enable or arm cancels a pending arm. This includes write-disable, a status write and cmd_other_i. A status write after the cancel is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_pin_n_i | input | 1 | Write-protect pin level, active low |
| busy_i | input | 1 | Internal operation in progress |
| cmd_wr_en_i | input | 1 | Write-enable command strobe |
| cmd_wr_dis_i | input | 1 | Write-disable command strobe |
| cmd_sr_arm_i | input | 1 | Arm-status-write command strobe |
| cmd_sr_write_i | input | 1 | Status write command strobe |
| sr_data_i | input | 8 | Data byte of the status write |
| cmd_other_i | input | 1 | Strobe for any other decoded command |
| prog_done_i | input | 1 | Byte program completed |
| erase_done_i | input | 1 | Sector, block or chip erase completed |
| incr_enter_i | input | 1 | Auto-increment program run started |
| incr_exit_i | input | 1 | Auto-increment run ended by command |
| incr_top_i | input | 1 | Auto-increment run reached top address |
| chk_addr_i | input | 24 | Address to test against the protection level |
| status_o | output | 8 | Register image |
| addr_prot_o | output | 1 | chk_addr_i lies in the protected region |
| chip_erase_ok_o | output | 1 | Whole-array erase permitted |

## Verification
The bench targets the boundaries of each protection level. It probes the first and last guarded byte, the byte just below the region, and addresses whose upper three bits are set. A decoder that is off by one level, or that reads bits 23:21, flags the wrong byte. It then follows the lock through each step: set it with the pin low, try a refused write, and clear it with the pin high. A design that lets the pin-low write through, or that clears the latch on refusal, reads back a different byte. It also sends a status write that is not armed, and one whose arm was cancelled by an unrelated command. A design without arm tracking accepts these writes.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int SR_W    = 8;
  localparam int B_BUSY  = 0;
  localparam int B_WLAT  = 1;
  localparam int B_PL_LO = 2;
  localparam int PL_W    = 4;
  localparam int B_INCR  = 6;
  localparam int B_LOCK  = 7;

  localparam logic [SR_W-1:0] SR_RESET = 8'h1C;
  // bits a status write may load: lock and the protection level
  localparam logic [SR_W-1:0] SR_WR_MASK = 8'hBC;
endpackage

// File: rtl/fsr_wr_gate.sv
module fsr_wr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr_en_i,
  input  logic cmd_sr_arm_i,
  input  logic cmd_sr_write_i,
  input  logic cmd_wr_dis_i,
  input  logic cmd_other_i,
  input  logic prot_pin_n_i,
  input  logic lock_i,
  output logic take_o
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      armed_q <= 1'b0;
    else if (cmd_wr_en_i || cmd_sr_arm_i)
      armed_q <= 1'b1;
    else if (cmd_sr_write_i || cmd_wr_dis_i || cmd_other_i)
      armed_q <= 1'b0;
  end

  assign take_o = cmd_sr_write_i && armed_q && (prot_pin_n_i || !lock_i);
endmodule

// File: rtl/fsr_regs.sv
module fsr_regs
  import fsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy_i,
  input  logic            take_i,
  input  logic [SR_W-1:0] data_i,
  input  logic            set_wlat_i,
  input  logic            clr_wlat_i,
  input  logic            incr_enter_i,
  input  logic            clr_incr_i,
  output logic [SR_W-1:0] sr_o
);
  logic [SR_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    sr_d[B_BUSY] = busy_i;
    if (take_i) begin
      sr_d = (data_i & SR_WR_MASK) | (sr_d & ~SR_WR_MASK);
      sr_d[B_WLAT] = 1'b0;
    end
    if (set_wlat_i) sr_d[B_WLAT] = 1'b1;
    if (incr_enter_i && sr_q[B_WLAT]) sr_d[B_INCR] = 1'b1;
    if (clr_wlat_i) sr_d[B_WLAT] = 1'b0;
    if (clr_incr_i) sr_d[B_INCR] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= SR_RESET;
    else        sr_q <= sr_d;
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/fsr_prot_decode.sv
module fsr_prot_decode #(
  parameter int ADDR_W = 24,
  parameter int MEM_AW = 21,
  parameter int LVL_W  = 3
) (
  input  logic [LVL_W-1:0]  level_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  localparam int PARTIAL = (1 << LVL_W) - 3;
  localparam logic [ADDR_W-1:0] SPACE_MASK = (ADDR_W'(1) << MEM_AW) - ADDR_W'(1);

  logic [ADDR_W-1:0] off;
  logic [PARTIAL:1]  hit;

  assign off = addr_i & SPACE_MASK;

  for (genvar i = 1; i <= PARTIAL; i++) begin : g_lvl
    localparam logic [ADDR_W-1:0] BASE =
      (ADDR_W'(1) << MEM_AW) - (ADDR_W'(1) << (MEM_AW - (PARTIAL + 1 - i)));
    assign hit[i] = (off >= BASE);
  end

  always_comb begin
    prot_o = (level_i > LVL_W'(PARTIAL));
    for (int i = 1; i <= PARTIAL; i++)
      if (level_i == LVL_W'(i)) prot_o = hit[i];
  end
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int MEM_AW = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_pin_n_i,
  input  logic              busy_i,
  input  logic              cmd_wr_en_i,
  input  logic              cmd_wr_dis_i,
  input  logic              cmd_sr_arm_i,
  input  logic              cmd_sr_write_i,
  input  logic [7:0]        sr_data_i,
  input  logic              cmd_other_i,
  input  logic              prog_done_i,
  input  logic              erase_done_i,
  input  logic              incr_enter_i,
  input  logic              incr_exit_i,
  input  logic              incr_top_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic [7:0]        status_o,
  output logic              addr_prot_o,
  output logic              chip_erase_ok_o
);
  logic            take;
  logic [SR_W-1:0] sr;
  logic            clr_incr, clr_wlat;

  assign clr_incr = cmd_wr_dis_i || incr_exit_i || incr_top_i;
  assign clr_wlat = clr_incr || prog_done_i || erase_done_i;

  fsr_wr_gate u_gate (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr_en_i(cmd_wr_en_i), .cmd_sr_arm_i(cmd_sr_arm_i),
    .cmd_sr_write_i(cmd_sr_write_i), .cmd_wr_dis_i(cmd_wr_dis_i),
    .cmd_other_i(cmd_other_i), .prot_pin_n_i(prot_pin_n_i),
    .lock_i(sr[B_LOCK]), .take_o(take)
  );

  fsr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .take_i(take),
    .data_i(sr_data_i), .set_wlat_i(cmd_wr_en_i), .clr_wlat_i(clr_wlat),
    .incr_enter_i(incr_enter_i), .clr_incr_i(clr_incr), .sr_o(sr)
  );

  fsr_prot_decode #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .LVL_W(PL_W-1)) u_dec (
    .level_i(sr[B_PL_LO +: PL_W-1]), .addr_i(chk_addr_i), .prot_o(addr_prot_o)
  );

  assign chip_erase_ok_o = (sr[B_PL_LO +: PL_W] == '0);
  assign status_o        = sr;
endmodule

// File: rtl/fsr_status_chk.sv
module fsr_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       prot_pin_n_i,
  input logic       busy_i,
  input logic       cmd_wr_en_i,
  input logic       cmd_wr_dis_i,
  input logic       cmd_sr_arm_i,
  input logic       cmd_sr_write_i,
  input logic       incr_enter_i,
  input logic       incr_exit_i,
  input logic       incr_top_i,
  input logic       prog_done_i,
  input logic       erase_done_i,
  input logic [7:0] status_o,
  input logic       addr_prot_o,
  input logic       chip_erase_ok_o
);
  assert_busy_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> status_o[0]);

  assert_wlat_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[1]) |-> $past(cmd_wr_en_i));

  assert_refuse_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sr_write_i && !prot_pin_n_i && status_o[7] && !cmd_wr_en_i && !cmd_wr_dis_i
     && !incr_enter_i && !incr_exit_i && !incr_top_i && !prog_done_i && !erase_done_i)
    |=> $stable(status_o[7:1]));

  assert_lock_oneway_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[7]) |-> $past(prot_pin_n_i));

  assert_clear_events_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_dis_i || incr_exit_i || incr_top_i) |=> (!status_o[1] && !status_o[6]));

  assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_done_i || erase_done_i) |=> !status_o[1]);

  assert_incr_needs_wlat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[6]) |-> ($past(status_o[1]) && $past(incr_enter_i)));

  assert_full_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[4:3] == 2'b11) |-> addr_prot_o);

  assert_erase_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_ok_o |-> !addr_prot_o);

  assert_status_write_needs_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(status_o[5:2]) || $changed(status_o[7])) |-> $past(cmd_sr_write_i));
endmodule

bind flash_status_reg fsr_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .prot_pin_n_i(prot_pin_n_i), .busy_i(busy_i),
  .cmd_wr_en_i(cmd_wr_en_i), .cmd_wr_dis_i(cmd_wr_dis_i),
  .cmd_sr_arm_i(cmd_sr_arm_i), .cmd_sr_write_i(cmd_sr_write_i),
  .incr_enter_i(incr_enter_i), .incr_exit_i(incr_exit_i), .incr_top_i(incr_top_i),
  .prog_done_i(prog_done_i), .erase_done_i(erase_done_i),
  .status_o(status_o), .addr_prot_o(addr_prot_o), .chip_erase_ok_o(chip_erase_ok_o)
);

// File: tb/flash_status_reg_tb.sv
module flash_status_reg_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prot_pin_n = 1'b1, busy = 1'b0;
  logic wr_en = 0, wr_dis = 0, sr_arm = 0, sr_wr = 0, other = 0;
  logic prog_done = 0, erase_done = 0, i_enter = 0, i_exit = 0, i_top = 0;
  logic [7:0]  sr_data = 8'h00;
  logic [23:0] addr = 24'h0;
  logic [7:0]  status;
  logic        aprot, ce_ok;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .prot_pin_n_i(prot_pin_n), .busy_i(busy),
    .cmd_wr_en_i(wr_en), .cmd_wr_dis_i(wr_dis), .cmd_sr_arm_i(sr_arm),
    .cmd_sr_write_i(sr_wr), .sr_data_i(sr_data), .cmd_other_i(other),
    .prog_done_i(prog_done), .erase_done_i(erase_done),
    .incr_enter_i(i_enter), .incr_exit_i(i_exit), .incr_top_i(i_top),
    .chk_addr_i(addr), .status_o(status), .addr_prot_o(aprot), .chip_erase_ok_o(ce_ok)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // codes: 0 wr_en 1 wr_dis 2 arm 3 sr_write 4 other 5 prog 6 erase 7 enter 8 exit 9 top
  task automatic cmd(input int code, input logic [7:0] d = 8'h00);
    @(negedge clk);
    sr_data = d;
    case (code)
      0: wr_en = 1; 1: wr_dis = 1; 2: sr_arm = 1; 3: sr_wr = 1; 4: other = 1;
      5: prog_done = 1; 6: erase_done = 1; 7: i_enter = 1; 8: i_exit = 1;
      default: i_top = 1;
    endcase
    @(negedge clk);
    {wr_en, wr_dis, sr_arm, sr_wr, other, prog_done, erase_done, i_enter, i_exit, i_top} = '0;
  endtask

  function automatic logic model_prot(input logic [2:0] lv, input logic [23:0] a);
    logic [20:0] off = a[20:0];
    if (lv == 0) return 1'b0;
    if (lv >= 6) return 1'b1;
    return {11'd0, off} >= (32'h20_0000 - (32'd1 << (15 + lv)));
  endfunction

  task automatic t_reset;
    check("R1 reset image", status, 8'h1C);
    check("R9 erase gate at reset", ce_ok, 1'b0);
  endtask

  task automatic t_busy;
    @(negedge clk); busy = 1;
    @(negedge clk); check("R2 busy seen", status, 8'h1D);
    cmd(2); cmd(3, 8'h00);
    check("R2 busy kept over write", status, 8'h01);
    check("R9 erase ok when level zero", ce_ok, 1'b1);
    @(negedge clk); busy = 0;
    @(negedge clk); check("R2 busy cleared", status, 8'h00);
  endtask

  task automatic t_arm;
    cmd(3, 8'h3C); check("R3 unarmed write ignored", status, 8'h00);
    cmd(2); cmd(4); cmd(3, 8'h3C); check("R10 arm cancelled by other", status, 8'h00);
    cmd(0); check("R3 latch set", status, 8'h02);
    cmd(3, 8'h4B); check("R5 write loads masked bits, clears latch", status, 8'h08);
    cmd(3, 8'h00); check("R10 second write not armed", status, 8'h08);
  endtask

  task automatic t_lock;
    @(negedge clk); prot_pin_n = 0;
    cmd(2); cmd(3, 8'h84); check("R5 lock set with pin low", status, 8'h84);
    cmd(0); check("R3 latch set under lock", status, 8'h86);
    cmd(3, 8'h00); check("R4 write refused, nothing changes", status, 8'h86);
    @(negedge clk); prot_pin_n = 1;
    cmd(2); cmd(3, 8'h00); check("R4 pin high lifts lock", status, 8'h00);
  endtask

  task automatic t_wlat_clear;
    for (int c = 0; c < 5; c++) begin
      int ev = (c == 0) ? 1 : (c == 1) ? 5 : (c == 2) ? 6 : (c == 3) ? 8 : 9;
      cmd(0); check("R6 latch set before event", status, 8'h02);
      cmd(ev); check("R6 latch cleared by event", status, 8'h00);
    end
  endtask

  task automatic t_incr;
    cmd(7); check("R7 enter ignored without latch", status, 8'h00);
    cmd(0); cmd(7); check("R7 enter with latch", status, 8'h42);
    cmd(1); check("R6 write-disable clears mode", status, 8'h00);
    cmd(0); cmd(7); cmd(9); check("R6 top clears mode", status, 8'h00);
    cmd(0); cmd(7); cmd(8); check("R6 exit clears mode", status, 8'h00);
  endtask

  task automatic t_prot;
    logic [23:0] probes [10] = '{24'h000000, 24'h1FFFFF, 24'h1F0000, 24'h1EFFFF,
      24'h100000, 24'h0FFFFF, 24'hE00000, 24'hFFFFFF, 24'h180000, 24'h17FFFF};
    for (int lv = 0; lv < 8; lv++) begin
      logic [2:0] l3 = 3'(lv);
      cmd(2); cmd(3, {2'b00, l3[0], l3, 2'b00});
      check("R9 erase gate vs level", ce_ok, (lv == 0) ? 1'b1 : 1'b0);
      for (int p = 0; p < 10; p++) begin
        @(negedge clk); addr = probes[p];
        #1 check("R8 protected region", aprot, model_prot(l3, probes[p]));
      end
    end
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_busy();
    t_arm();
    t_lock();
    t_wlat_clear();
    t_incr();
    t_prot();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule